// File: doc/BRIEF.md
# Serial SAR ADC Control Front End

This block is the digital side of an eight-input, 12-bit successive-approximation converter that a host reaches over a three-wire serial port: an active-low select, a serial clock and a data input. All of its logic runs on the serial clock. Data in is sampled on rising edges and the outputs change on falling edges. While select is low, the block skips zeros on the data line until it sees a one. It takes that one as the start of an eight-bit control word, decodes the input selection, the input mode and the power-down setting, and runs an acquire phase, a hold instant and a twelve-clock conversion.

There is no analog comparator. A 12-bit `sample` input stands in for the converter core and is captured at the hold instant. The result is shifted out most significant bit first as straight binary, followed by zeros. The control word for the next conversion may arrive while the current result is still being shifted out, so one conversion can complete every fifteen clocks. A power tracker combines the requested power-down setting with the active-low shutdown input. The two output drivers are enabled only while the block is selected.

Top module: `adc_serial_front`

## Requirements
- R1: While `cs_n` is high, `out_en` is 0 and `din` has no effect. A one on `din` during such a rising edge does not start a frame.
- R2: While the block is hunting, rising edges with `din` = 0 are skipped. The first rising edge with `cs_n` low and `din` = 1 is the start bit and is counted as frame edge 1.
- R3: Frame edges 2 to 8 carry, in this order: select bits S2, S1, S0, one don't-care bit, the mode bit, and power bits P1, P0. `chan` takes {S2,S1,S0} on edge 4 and keeps its old value until then. `single_ended` takes the mode bit on edge 6.
- R4: `acq` is 1 after frame edges 5, 6 and 7, and 0 otherwise. It falls on edge 8.
- R5: `sample` is captured on frame edge 8, the hold instant. Changes to `sample` after that edge do not alter the result.
- R6: `busy` is 1 only during the clock that follows edge 8, from the falling edge after edge 8 to the falling edge after edge 9. `dout` is 0 during that clock.
- R7: After the falling edge that follows frame edge 8+k (k = 1..12), `dout` holds result bit 12-k, so the MSB comes first. From the falling edge after edge 21, `dout` is 0.
- R8: `din` on frame edges 9 to 15 is ignored. A new start bit is accepted from frame edge 16 onward. Its control word then overlaps the readout of the previous result, and the previous result still comes out intact.
- R9: P1:P0 = 00 selects auto power-down: `pwr_up` is 1 only while acquiring or converting. Any other code keeps `pwr_up` at 1 after the control word is complete. `pwr_up` is always 1 while a conversion is running and `shdn_n` is high.
- R10: `shdn_n` low drives `pwr_up` to 0 at once, with no clock edge needed.
- R11: The result is straight binary: codes 0x000 and 0xFFF come out as all zeros and all ones.
- R12: A rising edge with `cs_n` high abandons any frame or conversion in progress. `acq` is 0 after it, and the next frame must begin with a new start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all state runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| din | input | 1 | Serial control data, sampled on rising edges |
| shdn_n | input | 1 | Active-low shutdown |
| sample | input | 12 | Digital stand-in for the converted value |
| dout | output | 1 | Serial result, updated on falling edges |
| busy | output | 1 | Busy flag, updated on falling edges |
| out_en | output | 1 | Enable for the dout and busy pad drivers |
| acq | output | 1 | Acquire phase in progress |
| chan | output | 3 | Decoded input selection |
| single_ended | output | 1 | Decoded mode, 1 = referenced to common |
| pwr_up | output | 1 | Converter core powered |

## Verification
The properties assume that `cs_n`, `din` and `sample` change only between edges and never at a rising edge. They also assume that a new frame cannot reach its hold instant while a conversion is still running, which the fifteen-clock lock-out enforces. The stimulus respects both conditions. Every input is driven one time unit after a falling edge, and outputs are sampled one time unit after the edge they depend on. Deselection is only asserted between complete frames or as a deliberate abort partway through a control word.

// File: rtl/adc_sif_pkg.sv
package adc_sif_pkg;

    // control word layout: start, 3 select bits, spare, mode, 2 power bits
    localparam int unsigned CTRL_BITS  = 8;
    localparam int unsigned SEL_W      = 3;
    localparam int unsigned PD_W       = 2;
    // edges from one start bit to the first edge that may carry the next
    localparam int unsigned FRAME_CLKS = 15;
    localparam int unsigned FCNT_W     = $clog2(FRAME_CLKS + 1);

    typedef enum logic [1:0] {
        PS_HUNT = 2'd0,
        PS_CTRL = 2'd1,
        PS_LOCK = 2'd2
    } parse_st_e;

    typedef struct packed {
        parse_st_e         st;
        logic [FCNT_W-1:0] cnt;
        logic [1:0]        sh;
        logic [SEL_W-1:0]  chan;
        logic              single;
        logic              acq;
    } parse_s;

endpackage

// File: rtl/adc_ctl_parse.sv
module adc_ctl_parse
    import adc_sif_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             din,
    output logic             acq_o,
    output logic [SEL_W-1:0] chan_o,
    output logic             single_o,
    output logic             hold_o,
    output logic             pd_vld_o,
    output logic [PD_W-1:0]  pd_o
);

    localparam logic [FCNT_W-1:0] E_SEL  = FCNT_W'(3);
    localparam logic [FCNT_W-1:0] E_ACQ  = FCNT_W'(4);
    localparam logic [FCNT_W-1:0] E_MODE = FCNT_W'(5);
    localparam logic [FCNT_W-1:0] E_LAST = FCNT_W'(CTRL_BITS - 1);
    localparam logic [FCNT_W-1:0] E_FREE = FCNT_W'(FRAME_CLKS - 1);

    parse_s q_q, q_d;

    always_comb begin
        q_d      = q_q;
        hold_o   = 1'b0;
        pd_vld_o = 1'b0;
        pd_o     = {q_q.sh[0], din};
        if (cs_n) begin
            q_d.st  = PS_HUNT;
            q_d.cnt = '0;
            q_d.acq = 1'b0;
        end else begin
            unique case (q_q.st)
                PS_HUNT: begin
                    if (din) begin
                        q_d.st  = PS_CTRL;
                        q_d.cnt = FCNT_W'(1);
                        q_d.sh  = '0;
                    end
                end
                PS_CTRL: begin
                    // cnt_q is the number of bits already taken, start included
                    q_d.cnt = q_q.cnt + FCNT_W'(1);
                    q_d.sh  = {q_q.sh[0], din};
                    if (q_q.cnt == E_SEL) begin
                        q_d.chan = {q_q.sh, din};
                    end
                    if (q_q.cnt == E_ACQ) begin
                        q_d.acq = 1'b1;
                    end
                    if (q_q.cnt == E_MODE) begin
                        q_d.single = din;
                    end
                    if (q_q.cnt == E_LAST) begin
                        q_d.acq  = 1'b0;
                        q_d.st   = PS_LOCK;
                        hold_o   = 1'b1;
                        pd_vld_o = 1'b1;
                    end
                end
                PS_LOCK: begin
                    q_d.cnt = q_q.cnt + FCNT_W'(1);
                    if (q_q.cnt == E_FREE) begin
                        q_d.st = PS_HUNT;
                    end
                end
                default: begin
                    q_d.st = PS_HUNT;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '{st: PS_HUNT, cnt: '0, sh: '0, chan: '0, single: 1'b0, acq: 1'b0};
        end else begin
            q_q <= q_d;
        end
    end

    assign acq_o    = q_q.acq;
    assign chan_o   = q_q.chan;
    assign single_o = q_q.single;

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
    parameter int unsigned RES_W = 12,
    localparam int unsigned CNT_W = $clog2(RES_W + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             hold,
    input  logic [RES_W-1:0] sample,
    output logic             busy_o,
    output logic             dout_o,
    output logic             active_o,
    output logic [CNT_W-1:0] phase_o
);

    localparam logic [CNT_W-1:0] PH_BUSY = CNT_W'(1);
    localparam logic [CNT_W-1:0] PH_MSB  = CNT_W'(2);
    localparam logic [CNT_W-1:0] PH_LAST = CNT_W'(RES_W + 1);

    typedef struct packed {
        logic [CNT_W-1:0] ph;
        logic [RES_W-1:0] res;
    } conv_s;

    typedef struct packed {
        logic busy;
        logic dout;
    } pin_s;

    conv_s q_q, q_d;
    pin_s  p_q, p_d;
    logic [CNT_W-1:0] bit_idx;

    always_comb begin
        q_d = q_q;
        if (cs_n) begin
            q_d.ph = '0;
        end else if (hold) begin
            q_d.ph  = PH_BUSY;
            q_d.res = sample;
        end else if (q_q.ph != '0) begin
            q_d.ph = (q_q.ph == PH_LAST) ? '0 : q_q.ph + CNT_W'(1);
        end
    end

    always_comb begin
        bit_idx   = PH_LAST - q_q.ph;
        p_d.busy  = (q_q.ph == PH_BUSY);
        p_d.dout  = 1'b0;
        if (q_q.ph >= PH_MSB) begin
            p_d.dout = q_q.res[bit_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign busy_o   = p_q.busy;
    assign dout_o   = p_q.dout;
    assign active_o = (q_q.ph != '0);
    assign phase_o  = q_q.ph;

endmodule

// File: rtl/adc_pwr_ctl.sv
module adc_pwr_ctl
    import adc_sif_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pd_vld,
    input  logic [PD_W-1:0] pd,
    input  logic            acq,
    input  logic            conv_act,
    input  logic            shdn_n,
    output logic            pwr_up_o
);

    logic keep_q, keep_d;

    always_comb begin
        keep_d = keep_q;
        if (pd_vld) begin
            // only the all-zero code selects auto power-down
            keep_d = (pd != '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            keep_q <= 1'b0;
        end else begin
            keep_q <= keep_d;
        end
    end

    assign pwr_up_o = shdn_n & (keep_q | acq | conv_act);

endmodule

// File: rtl/adc_serial_front.sv
module adc_serial_front
    import adc_sif_pkg::*;
#(
    parameter int unsigned RES_W = 12,
    localparam int unsigned CNT_W = $clog2(RES_W + 2)
) (
    input  logic             sclk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             din,
    input  logic             shdn_n,
    input  logic [RES_W-1:0] sample,
    output logic             dout,
    output logic             busy,
    output logic             out_en,
    output logic             acq,
    output logic [SEL_W-1:0] chan,
    output logic             single_ended,
    output logic             pwr_up
);

    logic            hold;
    logic            pd_vld;
    logic [PD_W-1:0] pd;
    logic            conv_act;
    logic [CNT_W-1:0] conv_phase;

    adc_ctl_parse u_parse (
        .clk      (sclk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .din      (din),
        .acq_o    (acq),
        .chan_o   (chan),
        .single_o (single_ended),
        .hold_o   (hold),
        .pd_vld_o (pd_vld),
        .pd_o     (pd)
    );

    adc_conv_seq #(.RES_W(RES_W)) u_conv (
        .clk      (sclk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .hold     (hold),
        .sample   (sample),
        .busy_o   (busy),
        .dout_o   (dout),
        .active_o (conv_act),
        .phase_o  (conv_phase)
    );

    adc_pwr_ctl u_pwr (
        .clk      (sclk),
        .rst_n    (rst_n),
        .pd_vld   (pd_vld),
        .pd       (pd),
        .acq      (acq),
        .conv_act (conv_act),
        .shdn_n   (shdn_n),
        .pwr_up_o (pwr_up)
    );

    // pad drivers for dout and busy float while deselected
    assign out_en = ~cs_n;

endmodule

// File: rtl/adc_serial_front_chk.sv
module adc_serial_front_chk #(
    parameter int unsigned CNT_W = 4
) (
    input logic             sclk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             shdn_n,
    input logic             acq,
    input logic             busy,
    input logic             pwr_up,
    input logic [CNT_W-1:0] conv_phase
);

    AST_DESELECT_ABORTS: assert property (@(posedge sclk) disable iff (!rst_n)
        cs_n |=> (conv_phase == '0 && !acq)); // R12

    AST_BUSY_ONE_CLOCK: assert property (@(negedge sclk) disable iff (!rst_n)
        busy |=> !busy); // R6

    AST_ACQ_ENDS_IN_HOLD: assert property (@(posedge sclk) disable iff (!rst_n)
        ($fell(acq) && !$past(cs_n)) |-> (conv_phase == CNT_W'(1))); // R4

    AST_SHDN_FORCES_OFF: assert property (@(posedge sclk) disable iff (!rst_n)
        !shdn_n |-> !pwr_up); // R10

    AST_CONV_POWERED: assert property (@(posedge sclk) disable iff (!rst_n)
        (conv_phase != '0 && shdn_n) |-> pwr_up); // R9

endmodule

bind adc_serial_front adc_serial_front_chk #(.CNT_W(CNT_W)) u_chk (
    .sclk       (sclk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .shdn_n     (shdn_n),
    .acq        (acq),
    .busy       (busy),
    .pwr_up     (pwr_up),
    .conv_phase (conv_phase)
);

// File: tb/tb_adc_serial_front.sv
module tb_adc_serial_front;

    localparam int CLK_PERIOD = 20;
    localparam int RES_W = 12;
    localparam int NV = 6;

    // control word, captured value, leading zeros before the start bit
    localparam logic [7:0]  V_CTRL [NV] = '{8'h87, 8'hD8, 8'hF5, 8'hA2, 8'hBC, 8'hE7};
    localparam logic [11:0] V_SMP  [NV] = '{12'hA5C, 12'h000, 12'hFFF, 12'h123, 12'h800, 12'h001};
    localparam int          V_LEAD [NV] = '{0, 3, 1, 5, 0, 2};

    logic sclk, rst_n, cs_n, din, shdn_n;
    logic [RES_W-1:0] sample;
    logic dout, busy, out_en, acq, single_ended, pwr_up;
    logic [2:0] chan;

    adc_serial_front #(.RES_W(RES_W)) dut (
        .sclk         (sclk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .din          (din),
        .shdn_n       (shdn_n),
        .sample       (sample),
        .dout         (dout),
        .busy         (busy),
        .out_en       (out_en),
        .acq          (acq),
        .chan         (chan),
        .single_ended (single_ended),
        .pwr_up       (pwr_up)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [2:0] exp_chan = 3'd0;
    logic       exp_keep = 1'b0;

    logic acq_s, pwr_s, single_s, busy_s, dout_s;
    logic [2:0] chan_s;

    initial sclk = 1'b0;
    always #(CLK_PERIOD/2) sclk = ~sclk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one serial clock: drive din, sample state after the rise, pins after the fall
    task automatic tick(input logic d);
        din = d;
        @(posedge sclk);
        #1;
        acq_s = acq; chan_s = chan; single_s = single_ended; pwr_s = pwr_up;
        @(negedge sclk);
        #1;
        busy_s = busy; dout_s = dout;
    endtask

    task automatic run_frame(input logic [7:0] ctrl, input logic [11:0] smp, input int lead);
        logic [11:0] got;
        got = '0;
        cs_n = 1'b0;
        sample = smp;
        for (int i = 0; i < lead; i++) begin
            tick(1'b0);
            check("R2 no frame on leading zero", {busy_s, acq_s}, 2'b00);
        end
        for (int k = 1; k <= 8; k++) begin
            tick(ctrl[8-k]);
            if (k == 3) check("R3 chan held before edge 4", chan_s, exp_chan);
            if (k == 4) check("R3 chan decode", chan_s, ctrl[6:4]);
            if (k == 6) check("R3 mode decode", single_s, ctrl[2]);
            check("R4 acquire window", acq_s, (k >= 5 && k <= 7));
            if (k == 8) begin
                check("R6 busy after hold", busy_s, 1'b1);
                check("R6 dout low while busy", dout_s, 1'b0);
                sample = ~smp;
            end
        end
        exp_chan = ctrl[6:4];
        exp_keep = (ctrl[1:0] != 2'b00);
        for (int k = 9; k <= 20; k++) begin
            tick(1'b0);
            got[20-k] = dout_s;
            if (k == 12) begin
                check("R6 busy low in readout", busy_s, 1'b0);
                check("R9 powered while converting", pwr_s, 1'b1);
            end
        end
        check("R7 R5 R11 result bits", got, smp);
        tick(1'b0);
        check("R7 zero fill", dout_s, 1'b0);
        check("R9 power after conversion", pwr_s, exp_keep);
        cs_n = 1'b1;
        tick(1'b0);
        check("R1 drivers off", out_en, 1'b0);
    endtask

    task automatic overlap_test();
        logic [7:0]  ca, cb;
        logic [11:0] sa, sb, ga, gb;
        logic        bz [1:36];
        logic        dz [1:36];
        logic        d;
        ca = 8'h9F; cb = 8'hC3; sa = 12'h5A3; sb = 12'hC3C;
        ga = '0; gb = '0;
        cs_n = 1'b0;
        sample = sa;
        for (int i = 1; i <= 36; i++) begin
            if (i <= 8)       d = ca[8-i];
            else if (i <= 15) d = 1'b1;
            else if (i <= 23) d = cb[23-i];
            else              d = 1'b0;
            tick(d);
            bz[i] = busy_s;
            dz[i] = dout_s;
            if (i == 8) sample = sb;
            if (i == 20) check("R8 second frame acquiring", acq_s, 1'b1);
        end
        for (int i = 9; i <= 20; i++) ga[20-i] = dz[i];
        for (int i = 24; i <= 35; i++) gb[35-i] = dz[i];
        check("R8 first result intact", ga, sa);
        check("R8 no start from locked ones", bz[16], 1'b0);
        check("R8 second hold busy", bz[23], 1'b1);
        check("R8 second result", gb, sb);
        check("R8 second chan", chan_s, cb[6:4]);
        exp_chan = cb[6:4];
        exp_keep = 1'b1;
        cs_n = 1'b1;
        tick(1'b0);
    endtask

    task automatic abort_test();
        logic [7:0] c;
        c = 8'hB7;
        cs_n = 1'b0;
        for (int k = 1; k <= 5; k++) tick(c[8-k]);
        check("R12 acquiring before abort", acq_s, 1'b1);
        exp_chan = c[6:4];
        cs_n = 1'b1;
        tick(1'b1);
        check("R12 abort clears acquire", acq_s, 1'b0);
        check("R1 drivers off on abort", out_en, 1'b0);
        tick(1'b1);
        check("R1 din ignored while deselected", acq_s, 1'b0);
        run_frame(8'hC7, 12'h3C5, 0);
    endtask

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; din = 1'b0; shdn_n = 1'b1; sample = '0;
        repeat (3) @(negedge sclk);
        #1;
        rst_n = 1'b1;
        cs_n = 1'b0;
        tick(1'b0);
        tick(1'b0);
        check("R2 reset idle acq", acq_s, 1'b0);
        check("R9 reset unpowered", pwr_s, 1'b0);
        check("R3 reset chan", chan_s, 3'd0);
        check("R3 reset mode", single_s, 1'b0);
        check("R6 reset busy", busy_s, 1'b0);
        check("R7 reset dout", dout_s, 1'b0);
        check("R1 drivers on when selected", out_en, 1'b1);
        cs_n = 1'b1;
        tick(1'b0);

        for (int v = 0; v < NV; v++) begin
            run_frame(V_CTRL[v], V_SMP[v], V_LEAD[v]);
        end

        // last vector asked for always-powered
        check("R9 kept powered", pwr_up, 1'b1);
        shdn_n = 1'b0;
        #1;
        check("R10 shutdown immediate", pwr_up, 1'b0);
        shdn_n = 1'b1;
        #1;
        check("R10 release restores", pwr_up, 1'b1);

        abort_test();
        overlap_test();

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule